// File: doc/BRIEF.md
# Sequential Configuration Register Port

This block holds a bank of ten 8-bit configuration registers and gives two ways into them. In parallel mode the registers are reached over the low byte of the wide data bus while a register-access strobe is held. There is no address bus: an internal write pointer and an internal read pointer each step through the bank, one register per accepted cycle, and wrap from the tenth register back to the first. Reads come back on a byte-wide output a fixed four cycles after they are requested, with a valid flag beside them.

In serial mode, a three-wire port with its own serial clock, serial data and serial enable shifts in 16-bit frames. Each frame is a target address followed by a data byte and can write any single register. The serial clock is sampled by the block clock, so the serial wires can come from a slow, unrelated source. If the serial enable and the register-access strobe are both asserted, that combination is illegal and nothing happens. When the access strobe is low, the data bus belongs to the memory path and the bank ignores it.

All register contents are exported flat for the surrounding logic. Two decoded bits are also brought out separately: the queue-count select and the clock-ratio hint.

Top module: `cfg_reg_port`

## Requirements
- R1: After reset every register holds 0x00, except registers 4 and 7 (addresses 0x4 and 0x7, slices 3 and 6 of `cfg_flat`), which hold 0x7F. `queue_mode` always equals bit 0 of register 3, and `fast_clk` always equals bit 7 of register 10. Register n sits at `cfg_flat[(n-1)*8 +: 8]`.
- R2: With `cfg_access`=1, `wr_en`=1 and `ser_en`=0, each clock edge stores `wr_data[7:0]` into the register at the write pointer and then advances the pointer. Register 1 is the first one written after the pointer is cleared. `wr_data` bits above 7 have no effect. A cycle with `wr_en`=0 leaves the pointer where it is.
- R3: The parallel write that follows a write to register 10 lands in register 1.
- R4: With `cfg_access`=1, `rd_en`=1 and `ser_en`=0, a read is accepted at a clock edge and returns the register at the read pointer. The value is captured at that edge. `rd_data` carries it with `rd_valid`=1 after the third edge following the accepting edge, which is four edges counting the accepting one.
- R5: Parallel reads step through registers 1 to 10 and wrap to register 1.
- R6: Both parallel pointers return to register 1 on reset and on every edge at which `cfg_access` is 0.
- R7: While `ser_en`=1 and `cfg_access`=1 together, no register changes, no read is accepted and no serial bit is taken in.
- R8: With `ser_en`=1 and `cfg_access`=0, each rising `ser_clk` takes in one bit of `ser_din`. A frame is 8 address bits followed by 8 data bits, most significant bit first. The write is made when the 16th bit arrives. Dropping `ser_en` discards a partial frame.
- R9: A serial frame whose address is 0x00 or greater than 0x0A changes no register.
- R10: With `cfg_access`=0, `wr_en` and `rd_en` change no register and produce no `rd_valid`.
- R11: `rd_data` is 0x00 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock for parallel access and for sampling the serial port |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| cfg_access | input | 1 | 1 = data bus targets the register bank, 0 = data bus belongs to the memory path |
| wr_en | input | 1 | Parallel write request |
| wr_data | input | BUS_W | Wide data bus; only bits 7:0 reach the bank |
| rd_en | input | 1 | Parallel read request |
| rd_data | output | 8 | Returned register byte |
| rd_valid | output | 1 | `rd_data` holds a returned register |
| ser_clk | input | 1 | Serial clock, sampled by `clk` |
| ser_din | input | 1 | Serial data bit |
| ser_en | input | 1 | Serial enable, active high |
| cfg_flat | output | NUM_REGS*8 | All register values, register 1 in the low byte |
| queue_mode | output | 1 | Queue-count select bit |
| fast_clk | output | 1 | Clock-ratio hint bit |

## Verification
The bench goes after the pointer edges. It runs write and read bursts that cross from register 10 back to register 1, and it pauses inside a burst. A design with an off-by-one wrap would write or read a register that does not exist, or skip register 1. A design that advanced the pointer on idle cycles would shift every later value by one slot. Read latency is checked on every cycle of a 13-read burst, so returning data a cycle early or late, or sampling the register after a later write, shows up as a data mismatch. Every serial address from 0x00 to 0x0F, plus 0x80 and 0xFF, is swept and compared against a model of the bank. The illegal strobe combination and the memory-path mode are also driven with live write and read requests, and any leaked write or spurious `rd_valid` is caught.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int unsigned CFG_W     = 8;
    localparam int unsigned QMODE_IDX = 2;
    localparam int unsigned QMODE_BIT = 0;
    localparam int unsigned FAST_IDX  = 9;
    localparam int unsigned FAST_BIT  = 7;

    typedef logic [CFG_W-1:0] cfg_byte_t;

    // Power-on value of the register in slot idx (slot 0 = address 0x1).
    function automatic cfg_byte_t reset_value(input int unsigned idx);
        return (idx == 3 || idx == 6) ? 8'h7F : 8'h00;
    endfunction

endpackage

// File: rtl/cfg_seq_ptr.sv
// Wrapping slot pointer: clears to slot 0, steps once per strobe.
module cfg_seq_ptr #(
    parameter int unsigned COUNT = 10,
    parameter int unsigned IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(COUNT - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d.idx = '0;
        end else if (step) begin
            ptr_d.idx = (ptr_q.idx == LAST) ? '0 : ptr_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign idx = ptr_q.idx;

endmodule

// File: rtl/cfg_serial_rx.sv
// Oversampled serial frame receiver: address then data, MSB first.
module cfg_serial_rx #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FRAME_W = ADDR_W + DATA_W,
    parameter int unsigned CNT_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_en,
    input  logic              blocked,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [2:0]         clk_pipe;
        logic [1:0]         din_pipe;
        logic [1:0]         en_pipe;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
    } rx_t;

    rx_t rx_d, rx_q;

    logic               active;
    logic               rise;
    logic [FRAME_W-1:0] frame;

    assign active = rx_q.en_pipe[1] && !blocked;
    assign rise   = rx_q.clk_pipe[1] && !rx_q.clk_pipe[2];
    assign frame  = {rx_q.shift[FRAME_W-2:0], rx_q.din_pipe[1]};

    always_comb begin
        rx_d          = rx_q;
        commit        = 1'b0;
        rx_d.clk_pipe = {rx_q.clk_pipe[1:0], ser_clk};
        rx_d.din_pipe = {rx_q.din_pipe[0], ser_din};
        rx_d.en_pipe  = {rx_q.en_pipe[0], ser_en};
        if (!active) begin
            rx_d.cnt = '0;
        end else if (rise) begin
            rx_d.shift = frame;
            if (rx_q.cnt == LAST_BIT) begin
                rx_d.cnt = '0;
                commit   = 1'b1;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign commit_addr = frame[FRAME_W-1:DATA_W];
    assign commit_data = frame[DATA_W-1:0];

endmodule

// File: rtl/cfg_rd_pipe.sv
// Fixed-latency return path for parallel register reads.
module cfg_rd_pipe #(
    parameter int unsigned W   = 8,
    parameter int unsigned LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    typedef struct packed {
        logic [LAT-1:0]        vld;
        logic [LAT-1:0][W-1:0] dat;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = {pipe_q.vld[LAT-2:0], in_valid};
        pipe_d.dat = {pipe_q.dat[LAT-2:0], (in_valid ? in_data : W'(0))};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.vld[LAT-1];
    assign out_data  = pipe_q.dat[LAT-1];

endmodule

// File: rtl/cfg_reg_port.sv
module cfg_reg_port
    import cfgport_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 10,
    parameter int unsigned BUS_W      = 36,
    parameter int unsigned RD_LATENCY = 4,
    parameter int unsigned SER_ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_access,
    input  logic                      wr_en,
    input  logic [BUS_W-1:0]          wr_data,
    input  logic                      rd_en,
    output logic [CFG_W-1:0]          rd_data,
    output logic                      rd_valid,
    input  logic                      ser_clk,
    input  logic                      ser_din,
    input  logic                      ser_en,
    output logic [NUM_REGS*CFG_W-1:0] cfg_flat,
    output logic                      queue_mode,
    output logic                      fast_clk
);

    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam logic [SER_ADDR_W-1:0] TOP_ADDR = SER_ADDR_W'(NUM_REGS);

    typedef struct packed {
        cfg_byte_t [NUM_REGS-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    logic                  wr_go, rd_go;
    logic [IDX_W-1:0]      wr_idx, rd_idx;
    logic                  ser_commit;
    logic [SER_ADDR_W-1:0] ser_addr;
    cfg_byte_t             ser_data;
    logic                  ser_addr_ok;
    logic [IDX_W-1:0]      ser_idx;
    logic                  unused_bus_hi;

    // ser_en alongside cfg_access is illegal: it blocks every path.
    assign wr_go = cfg_access && wr_en && !ser_en;
    assign rd_go = cfg_access && rd_en && !ser_en;
    assign unused_bus_hi = ^wr_data[BUS_W-1:CFG_W];

    cfg_seq_ptr #(.COUNT(NUM_REGS), .IDX_W(IDX_W)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!cfg_access),
        .step  (wr_go),
        .idx   (wr_idx)
    );

    cfg_seq_ptr #(.COUNT(NUM_REGS), .IDX_W(IDX_W)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!cfg_access),
        .step  (rd_go),
        .idx   (rd_idx)
    );

    cfg_serial_rx #(.ADDR_W(SER_ADDR_W), .DATA_W(CFG_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_din     (ser_din),
        .ser_en      (ser_en),
        .blocked     (cfg_access),
        .commit      (ser_commit),
        .commit_addr (ser_addr),
        .commit_data (ser_data)
    );

    assign ser_addr_ok = (ser_addr != '0) && (ser_addr <= TOP_ADDR);
    assign ser_idx     = IDX_W'(ser_addr - 1'b1);

    always_comb begin
        bank_d = bank_q;
        if (wr_go) begin
            bank_d.regs[wr_idx] = wr_data[CFG_W-1:0];
        end
        if (ser_commit && ser_addr_ok) begin
            bank_d.regs[ser_idx] = ser_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < NUM_REGS; i++) begin
                bank_q.regs[i] <= reset_value(i);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    cfg_rd_pipe #(.W(CFG_W), .LAT(RD_LATENCY)) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_go),
        .in_data   (bank_q.regs[rd_idx]),
        .out_valid (rd_valid),
        .out_data  (rd_data)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign cfg_flat[g*CFG_W +: CFG_W] = bank_q.regs[g];
    end

    assign queue_mode = bank_q.regs[QMODE_IDX][QMODE_BIT];
    assign fast_clk   = bank_q.regs[FAST_IDX][FAST_BIT];

endmodule

// File: rtl/cfg_reg_port_chk.sv
module cfg_reg_port_chk
    import cfgport_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 10,
    parameter int unsigned BUS_W      = 36,
    parameter int unsigned RD_LATENCY = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_access,
    input logic                      wr_en,
    input logic [BUS_W-1:0]          wr_data,
    input logic                      rd_en,
    input logic [CFG_W-1:0]          rd_data,
    input logic                      rd_valid,
    input logic                      ser_en,
    input logic [NUM_REGS*CFG_W-1:0] cfg_flat
);

    function automatic logic [NUM_REGS*CFG_W-1:0] defaults_flat();
        logic [NUM_REGS*CFG_W-1:0] v;
        v = '0;
        for (int unsigned i = 0; i < NUM_REGS; i++) begin
            v[i*CFG_W +: CFG_W] = reset_value(i);
        end
        return v;
    endfunction

    logic                  after_rst_q;
    logic [RD_LATENCY-1:0] req_hist_q;
    logic                  unused_wr_data;

    assign unused_wr_data = ^wr_data;

    always_ff @(posedge clk) begin
        after_rst_q <= !rst_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_hist_q <= '0;
        end else begin
            req_hist_q <= {req_hist_q[RD_LATENCY-2:0], (rd_en && cfg_access && !ser_en)};
        end
    end

    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst_q |-> (cfg_flat == defaults_flat()));

    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == req_hist_q[RD_LATENCY-1]);

    p_illegal_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_access && ser_en) |=> $stable(cfg_flat));

    p_no_strobe_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_access && !wr_en) |=> $stable(cfg_flat));

    p_idle_data_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

endmodule

bind cfg_reg_port cfg_reg_port_chk #(
    .NUM_REGS   (NUM_REGS),
    .BUS_W      (BUS_W),
    .RD_LATENCY (RD_LATENCY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_access (cfg_access),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .ser_en     (ser_en),
    .cfg_flat   (cfg_flat)
);

// File: tb/cfg_reg_port_test.sv
module cfg_reg_port_test;

    localparam int NR = 10;
    localparam int BW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_access = 1'b0;
    logic          wr_en = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          ser_clk = 1'b0;
    logic          ser_din = 1'b0;
    logic          ser_en = 1'b0;
    logic [NR*8-1:0] cfg_flat;
    logic          queue_mode;
    logic          fast_clk;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [NR];
    int wp = 0;
    int rp = 0;

    cfg_reg_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_access(cfg_access), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .ser_clk(ser_clk), .ser_din(ser_din), .ser_en(ser_en),
        .cfg_flat(cfg_flat), .queue_mode(queue_mode), .fast_clk(fast_clk)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) model[i] = (i == 3 || i == 6) ? 8'h7F : 8'h00;
        wp = 0;
        rp = 0;
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NR; i++)
            chk(cfg_flat[i*8 +: 8] == model[i], req, 32'(cfg_flat[i*8 +: 8]), 32'(model[i]));
        chk(queue_mode == model[2][0], {req, " R1 queue_mode"}, 32'(queue_mode), 32'(model[2][0]));
        chk(fast_clk == model[9][7], {req, " R1 fast_clk"}, 32'(fast_clk), 32'(model[9][7]));
    endtask

    task automatic leave_access();
        cfg_access = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        tick();
        wp = 0;
        rp = 0;
    endtask

    task automatic pwrite(input int n, input int seed);
        cfg_access = 1'b1;
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'(seed + 29 * k);
            wr_en = 1'b1;
            wr_data = {28'hA5C3F1E, v};
            tick();
            model[wp] = v;
            wp = (wp + 1) % NR;
        end
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic pread(input int n);
        int base;
        cfg_access = 1'b0;
        tick();
        rp = 0;
        base = rp;
        cfg_access = 1'b1;
        for (int c = 0; c < n + 5; c++) begin
            int e;
            bit exp_v;
            logic [7:0] exp_d;
            rd_en = (c < n);
            tick();
            e = c + 1;
            exp_v = (e >= 4) && (e - 4 < n);
            exp_d = exp_v ? model[(base + e - 4) % NR] : 8'h00;
            chk(rd_valid == exp_v, "R4 rd_valid timing", 32'(rd_valid), 32'(exp_v));
            chk(rd_data == exp_d, "R4/R5 rd_data sequence", 32'(rd_data), 32'(exp_d));
        end
        rd_en = 1'b0;
        rp = (base + n) % NR;
    endtask

    task automatic send_frame(input logic [7:0] addr, input logic [7:0] data, input bit legal);
        logic [15:0] f;
        f = {addr, data};
        for (int b = 15; b >= 0; b--) begin
            ser_din = f[b];
            ser_clk = 1'b0;
            repeat (3) tick();
            ser_clk = 1'b1;
            repeat (3) tick();
        end
        ser_clk = 1'b0;
        repeat (4) tick();
        if (legal && addr >= 8'h01 && addr <= 8'h0A) model[addr - 1] = data;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) tick();
        check_bank("R1 defaults in reset");
        rst_n = 1'b1;
        tick();
        check_bank("R1 defaults after reset");
        chk(rd_valid == 1'b0, "R11 idle valid", 32'(rd_valid), 0);

        // R2: full sweep of the bank, upper bus bits carry junk
        pwrite(NR, 8'h11);
        check_bank("R2 write sweep");
        // R3: three more writes wrap to register 1
        pwrite(3, 8'h81);
        check_bank("R3 write wrap");
        // R2: pause inside a burst keeps the pointer
        repeat (2) tick();
        pwrite(1, 8'hE7);
        check_bank("R2 paused burst");
        // R6: leaving access clears the pointer
        leave_access();
        pwrite(2, 8'h3C);
        check_bank("R6 pointer clear");

        // R4/R5: 13-read burst crosses the wrap
        pread(13);
        leave_access();

        // R10: requests while the bus belongs to memory
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 36'h0_0000_00FF;
        for (int c = 0; c < 8; c++) begin
            tick();
            chk(rd_valid == 1'b0, "R10 no read in memory mode", 32'(rd_valid), 0);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        check_bank("R10 no write in memory mode");

        // R7: illegal combination with live requests and a serial frame
        cfg_access = 1'b1; ser_en = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
        wr_data = 36'h0_0000_0055;
        for (int c = 0; c < 8; c++) begin
            tick();
            chk(rd_valid == 1'b0, "R7 no read when illegal", 32'(rd_valid), 0);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        send_frame(8'h02, 8'hAA, 1'b0);
        check_bank("R7 illegal has no effect");
        ser_en = 1'b0;
        tick();
        leave_access();

        // R8/R9: serial sweep over every low address plus far ones
        ser_en = 1'b1;
        repeat (3) tick();
        for (int a = 0; a < 16; a++) begin
            send_frame(8'(a), 8'(a * 37 + 5), 1'b1);
            check_bank((a >= 1 && a <= NR) ? "R8 serial write" : "R9 serial out of range");
        end
        send_frame(8'h80, 8'h99, 1'b1);
        send_frame(8'hFF, 8'h66, 1'b1);
        check_bank("R9 high addresses ignored");
        send_frame(8'h0A, 8'h80, 1'b1);
        send_frame(8'h03, 8'h01, 1'b1);
        check_bank("R8 R1 decoded bits set");
        // R8: partial frame discarded when enable drops
        ser_din = 1'b1;
        for (int b = 0; b < 5; b++) begin
            ser_clk = 1'b0; repeat (3) tick();
            ser_clk = 1'b1; repeat (3) tick();
        end
        ser_clk = 1'b0;
        ser_en = 1'b0;
        repeat (3) tick();
        ser_en = 1'b1;
        repeat (3) tick();
        send_frame(8'h05, 8'h4D, 1'b1);
        check_bank("R8 partial frame discarded");
        ser_en = 1'b0;
        repeat (3) tick();

        // Read back serial results, then reset mid-run
        pread(NR);
        leave_access();
        rst_n = 1'b0;
        tick();
        model_reset();
        rst_n = 1'b1;
        tick();
        check_bank("R1 defaults after second reset");
        pwrite(1, 8'hC4);
        check_bank("R6 pointer at register 1 after reset");
        leave_access();

        finish_run();
    end

endmodule